// File: doc/BRIEF.md
# Adaptive FIR Filter with Delayed Least-Mean-Squares Update

This block is an adaptive finite-impulse-response filter. Each time a sample strobe is raised it takes one input sample and one desired-response sample. It forms the filter output as the dot product of the most recent input samples with its tap weights, and it reports the error as the desired response minus the output. Every tap product is formed at once and summed by an adder tree. The tap weights are then corrected by the least-mean-squares rule.

The correction does not use the error that was just computed. Each error, together with the input vector that produced it, goes into a short history. The weight update reads the entry that is a fixed number of samples old. The FIR sum and the update datapath are therefore separated by registers. The cost is slower convergence, because the loop reacts some samples late.

The step size is a power of two, so the scaling is an arithmetic right shift. Data and weights are signed Q1.15 (bit 15 is the sign, one unit equals 32768). Adaptation can be frozen with an enable input. A synchronous reset clears all state.

Top module: `lms_adapt_filter`

## Requirements
- R1: While `rst` is high at a rising edge, the following are all cleared to zero by that edge: the weights, the input delay line, the error history, `y_out` and `e_out`. `out_vld` is driven low.
- R2: A strobe on `smp_vld` that is sampled at rising edge k gives `out_vld` high for exactly one cycle after edge k+1. The `y_out` and `e_out` of that sample appear in the same cycle. Strobes may arrive on consecutive cycles.
- R3: The output for sample n is the sum over i of w_n[i]·x[n−i], for i from 0 to NTAPS−1. Inputs from before the first sample since reset count as zero. The sum is rounded by adding 2^14 and shifting arithmetically right by 15, then saturated to the range −32768 to 32767.
- R4: The error for sample n is d[n] − y[n], saturated to the range −32768 to 32767.
- R5: When `adapt_en` is high, the weights for the next sample are w_{n+1}[i] = sat16(w_n[i] + ((e[n−D]·x[n−D−i]) >>> (15+MU_SHIFT))), where D = UPD_DLY and the shift is a floor shift.
- R6: The update uses an error exactly D samples old. Errors from before reset count as zero, so after a reset the outputs y[0] through y[D] are formed with all-zero weights.
- R7: When `adapt_en` is low while a sample is processed, the weights stay unchanged. With zero weights, y is 0 and e equals d.
- R8: Given white-noise input and a desired signal produced by a fixed 4-tap FIR, the mean squared error over samples 1744 to 1999 after reset is below 40000 and below 1/16 of its value over samples 0 to 255.
- R9: Idle cycles between strobes change no state. Results depend only on the sequence of samples, not on how they are spaced.
- R10: Weights saturate at the Q1.15 limits instead of wrapping. A constant input of 1024 with a desired value of 32767 drives every weight to 32767 and the output to 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adapt_en | input | 1 | Weight adaptation enable |
| smp_vld | input | 1 | Strobe: x_in and d_in hold a new sample |
| x_in | input | 16 | Input sample, signed Q1.15 |
| d_in | input | 16 | Desired-response sample, signed Q1.15 |
| out_vld | output | 1 | Strobe: y_out and e_out hold a new result |
| y_out | output | 16 | Filter output, signed Q1.15 |
| e_out | output | 16 | Error d − y, signed Q1.15 |

## Verification
The output and error of a sample appear two rising edges after its strobe. A weight correction computed at that second edge first affects the next sample, and it is built from the error of the sample D strobes earlier. The bench drives inputs and reads outputs on falling edges. A monitor pairs each `out_vld` pulse, in order, with a result the bench predicted from the arithmetic in the requirements, so strobe spacing cannot shift the comparison. The delay test counts samples after reset to find the first non-zero output, and the latency test counts the falling edges between one isolated strobe and its result.

// File: rtl/lms_pkg.sv
package lms_pkg;
   localparam int SW   = 16;
   localparam int FRAC = 15;
   localparam int WIDE = 48;

   typedef logic signed [SW-1:0] smp_t;

   localparam logic signed [WIDE-1:0] W_MAX = (48'sd1 <<< (SW-1)) - 48'sd1;
   localparam logic signed [WIDE-1:0] W_MIN = -(48'sd1 <<< (SW-1));

   function automatic smp_t sat_wide(input logic signed [WIDE-1:0] v);
      if (v > W_MAX) return smp_t'(W_MAX[SW-1:0]);
      if (v < W_MIN) return smp_t'(W_MIN[SW-1:0]);
      return smp_t'(v[SW-1:0]);
   endfunction

   function automatic logic signed [WIDE-1:0] rnd_shift(input logic signed [WIDE-1:0] v);
      return (v + (48'sd1 <<< (FRAC-1))) >>> FRAC;
   endfunction
endpackage

// File: rtl/lms_tap_line.sv
module lms_tap_line
   import lms_pkg::*;
#(
   parameter int NTAPS = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      shift,
   input  smp_t                      din,
   output logic [NTAPS-1:0][SW-1:0]  taps
);
   always_ff @(posedge clk) begin
      if (rst) begin
         taps <= '0;
      end else if (shift) begin
         taps[0] <= din;
         for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
      end
   end

   // R9
   tap_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !shift |=> $stable(taps));

   for (genvar i = 1; i < NTAPS; i++) begin : g_chk
      // R3
      tap_order_chk: assert property (@(posedge clk) disable iff (rst)
         shift |=> taps[i] == $past(taps[i-1]));
   end
endmodule

// File: rtl/lms_dot_tree.sv
module lms_dot_tree
   import lms_pkg::*;
#(
   parameter int NTAPS = 4,
   parameter int AW    = 2*SW + 3
) (
   input  logic [NTAPS-1:0][SW-1:0] taps,
   input  logic [NTAPS-1:0][SW-1:0] wts,
   output logic signed [AW-1:0]     acc
);
   localparam int LV = $clog2(NTAPS);
   localparam int P2 = 1 << LV;

   logic signed [AW-1:0] node [1:2*P2-1];

   for (genvar i = 0; i < P2; i++) begin : g_leaf
      if (i < NTAPS) begin : g_prod
         logic signed [2*SW-1:0] prd;
         assign prd = $signed(taps[i]) * $signed(wts[i]);
         assign node[P2+i] = AW'(prd);
      end else begin : g_pad
         assign node[P2+i] = '0;
      end
   end

   for (genvar k = 1; k < P2; k++) begin : g_add
      assign node[k] = node[2*k] + node[2*k+1];
   end

   assign acc = node[1];
endmodule

// File: rtl/lms_err_hist.sv
module lms_err_hist
   import lms_pkg::*;
#(
   parameter int NTAPS = 4,
   parameter int DLY   = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     push,
   input  smp_t                     e_in,
   input  logic [NTAPS-1:0][SW-1:0] xv_in,
   output smp_t                     e_old,
   output logic [NTAPS-1:0][SW-1:0] xv_old
);
   smp_t                     eh [DLY];
   logic [NTAPS-1:0][SW-1:0] xh [DLY];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < DLY; k++) begin
            eh[k] <= '0;
            xh[k] <= '0;
         end
      end else if (push) begin
         eh[0] <= e_in;
         xh[0] <= xv_in;
         for (int k = 1; k < DLY; k++) begin
            eh[k] <= eh[k-1];
            xh[k] <= xh[k-1];
         end
      end
   end

   assign e_old  = eh[DLY-1];
   assign xv_old = xh[DLY-1];

   // R9
   hist_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !push |=> ($stable(e_old) && $stable(xv_old)));
endmodule

// File: rtl/lms_weight_bank.sv
module lms_weight_bank
   import lms_pkg::*;
#(
   parameter int NTAPS    = 4,
   parameter int MU_SHIFT = 3
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     fire,
   input  smp_t                     err,
   input  logic [NTAPS-1:0][SW-1:0] xv,
   output logic [NTAPS-1:0][SW-1:0] wts
);
   localparam int SH = FRAC + MU_SHIFT;

   smp_t nxt [NTAPS];
   logic neg [NTAPS];

   for (genvar i = 0; i < NTAPS; i++) begin : g_tap
      logic signed [2*SW-1:0] prd;
      logic signed [2*SW-1:0] dlt;
      logic signed [WIDE-1:0] sum;
      assign prd    = $signed(err) * $signed(xv[i]);
      assign dlt    = prd >>> SH;
      assign sum    = WIDE'($signed(wts[i])) + WIDE'(dlt);
      assign nxt[i] = sat_wide(sum);
      assign neg[i] = dlt[2*SW-1];

      // R10
      wt_rise_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
         (fire && !neg[i]) |=> $signed(wts[i]) >= $past($signed(wts[i])));
      // R10
      wt_fall_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
         (fire && neg[i]) |=> $signed(wts[i]) <= $past($signed(wts[i])));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wts <= '0;
      end else if (fire) begin
         for (int i = 0; i < NTAPS; i++) wts[i] <= nxt[i];
      end
   end

   // R7
   wt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !fire |=> $stable(wts));
endmodule

// File: rtl/lms_adapt_filter.sv
module lms_adapt_filter
   import lms_pkg::*;
#(
   parameter int NTAPS    = 4,
   parameter int MU_SHIFT = 3,
   parameter int UPD_DLY  = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 adapt_en,
   input  logic                 smp_vld,
   input  logic signed [SW-1:0] x_in,
   input  logic signed [SW-1:0] d_in,
   output logic                 out_vld,
   output logic signed [SW-1:0] y_out,
   output logic signed [SW-1:0] e_out
);
   localparam int LV = $clog2(NTAPS);
   localparam int AW = 2*SW + LV + 1;

   if (NTAPS < 1) begin : g_bad_taps
      $error("lms_adapt_filter: NTAPS must be at least 1");
   end
   if (UPD_DLY < 1) begin : g_bad_dly
      $error("lms_adapt_filter: UPD_DLY must be at least 1");
   end
   if (MU_SHIFT < 0 || MU_SHIFT > FRAC) begin : g_bad_mu
      $error("lms_adapt_filter: MU_SHIFT out of range");
   end
   if (AW + 1 > WIDE) begin : g_bad_aw
      $error("lms_adapt_filter: accumulator exceeds internal width");
   end

   logic                     v1;
   smp_t                     d1;
   logic [NTAPS-1:0][SW-1:0] taps;
   logic [NTAPS-1:0][SW-1:0] wts;
   logic signed [AW-1:0]     acc;
   smp_t                     y_nxt;
   smp_t                     e_nxt;
   smp_t                     e_old;
   logic [NTAPS-1:0][SW-1:0] xv_old;
   logic                     fire;

   lms_tap_line #(.NTAPS(NTAPS)) u_taps (
      .clk   (clk),
      .rst   (rst),
      .shift (smp_vld),
      .din   (x_in),
      .taps  (taps)
   );

   lms_dot_tree #(.NTAPS(NTAPS), .AW(AW)) u_dot (
      .taps (taps),
      .wts  (wts),
      .acc  (acc)
   );

   assign y_nxt = sat_wide(rnd_shift(WIDE'(acc)));
   assign e_nxt = sat_wide(WIDE'(d1) - WIDE'(y_nxt));
   assign fire  = v1 & adapt_en;

   lms_err_hist #(.NTAPS(NTAPS), .DLY(UPD_DLY)) u_hist (
      .clk    (clk),
      .rst    (rst),
      .push   (v1),
      .e_in   (e_nxt),
      .xv_in  (taps),
      .e_old  (e_old),
      .xv_old (xv_old)
   );

   lms_weight_bank #(.NTAPS(NTAPS), .MU_SHIFT(MU_SHIFT)) u_wts (
      .clk  (clk),
      .rst  (rst),
      .fire (fire),
      .err  (e_old),
      .xv   (xv_old),
      .wts  (wts)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         v1      <= 1'b0;
         d1      <= '0;
         out_vld <= 1'b0;
         y_out   <= '0;
         e_out   <= '0;
      end else begin
         v1      <= smp_vld;
         out_vld <= v1;
         if (smp_vld) d1 <= d_in;
         if (v1) begin
            y_out <= y_nxt;
            e_out <= e_nxt;
         end
      end
   end

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_vld && y_out == '0 && e_out == '0));

   // R2
   out_latency_chk: assert property (@(posedge clk) disable iff (rst)
      smp_vld |-> ##2 out_vld);

   // R2
   out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(smp_vld) |=> !out_vld);
endmodule

// File: tb/lms_adapt_filter_tb_top.sv
module lms_adapt_filter_tb_top;
   localparam int CLK_P = 10;
   localparam int NT    = 4;
   localparam int MU    = 3;
   localparam int DL    = 2;
   localparam int MAXS  = 4096;
   localparam int WD    = 150000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic adapt_en = 1'b0;
   logic smp_vld = 1'b0;
   logic signed [15:0] x_in = '0;
   logic signed [15:0] d_in = '0;
   logic out_vld;
   logic signed [15:0] y_out;
   logic signed [15:0] e_out;

   always #(CLK_P/2) clk = ~clk;

   lms_adapt_filter #(.NTAPS(NT), .MU_SHIFT(MU), .UPD_DLY(DL)) dut_i (
      .clk      (clk),
      .rst      (rst),
      .adapt_en (adapt_en),
      .smp_vld  (smp_vld),
      .x_in     (x_in),
      .d_in     (d_in),
      .out_vld  (out_vld),
      .y_out    (y_out),
      .e_out    (e_out)
   );

   int nchk = 0;
   int nerr = 0;
   int nsent = 0;
   int nrecv = 0;
   bit done = 0;
   bit [31:0] seed = 32'h1234_5677;

   int exp_y [MAXS];
   int exp_e [MAXS];
   int got_y [MAXS];
   int got_e [MAXS];
   int sd    [MAXS];

   longint mw [NT];
   longint mx [NT];
   longint he [DL];
   longint hx [DL][NT];
   longint sx [NT];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint sat16(input longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic int rnd14();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return int'($signed(seed[13:0]));
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NT; i++) begin
         mw[i] = 0;
         mx[i] = 0;
         sx[i] = 0;
      end
      for (int k = 0; k < DL; k++) begin
         he[k] = 0;
         for (int i = 0; i < NT; i++) hx[k][i] = 0;
      end
   endtask

   task automatic model_step(input int x, input int d);
      longint acc, y, e;
      for (int i = NT-1; i > 0; i--) mx[i] = mx[i-1];
      mx[0] = x;
      acc = 0;
      for (int i = 0; i < NT; i++) acc += mw[i] * mx[i];
      y = sat16((acc + 16384) >>> 15);
      e = sat16(d - y);
      if (adapt_en)
         for (int i = 0; i < NT; i++)
            mw[i] = sat16(mw[i] + ((he[DL-1] * hx[DL-1][i]) >>> (15 + MU)));
      for (int k = DL-1; k > 0; k--) begin
         he[k] = he[k-1];
         for (int i = 0; i < NT; i++) hx[k][i] = hx[k-1][i];
      end
      he[0] = e;
      for (int i = 0; i < NT; i++) hx[0][i] = mx[i];
      exp_y[nsent] = int'(y);
      exp_e[nsent] = int'(e);
   endtask

   task automatic send(input int x, input int d, input int gap);
      smp_vld = 1'b1;
      x_in = 16'(x);
      d_in = 16'(d);
      model_step(x, d);
      sd[nsent] = d;
      nsent++;
      @(negedge clk);
      smp_vld = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic drain();
      repeat (4) @(negedge clk);
      chk(nrecv == nsent, "R2 result count", nrecv, nsent);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R1: outputs cleared while reset is held
      chk(!out_vld && y_out == 0 && e_out == 0, "R1 reset outputs",
          {out_vld, y_out, e_out}, 0);
      rst = 1'b0;
      model_reset();
   endtask

   // monitor: pair each result with its prediction (R3/R4/R5/R9)
   always @(negedge clk) begin
      if (!rst && out_vld) begin
         got_y[nrecv] = y_out;
         got_e[nrecv] = e_out;
         chk(y_out == exp_y[nrecv], "R3/R5/R9 y_out", y_out, exp_y[nrecv]);
         chk(e_out == exp_e[nrecv], "R4/R5/R9 e_out", e_out, exp_e[nrecv]);
         nrecv++;
      end
   end

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int base, h [NT], w0, yv;
      longint m_first, m_last, dacc;
      h = '{16384, -8192, 4096, -2048};
      model_reset();
      @(negedge clk);
      do_reset();

      // R2: one isolated strobe, result exactly two edges later, one cycle wide
      adapt_en = 1'b0;
      send(1000, 300, 0);
      chk(out_vld == 1'b0, "R2 not after first edge", out_vld, 0);
      @(negedge clk);
      chk(out_vld == 1'b1, "R2 valid after second edge", out_vld, 1);
      @(negedge clk);
      chk(out_vld == 1'b0, "R2 single pulse", out_vld, 0);
      drain();

      // R7: adaptation off, weights stay zero, y=0 and e=d
      base = nsent;
      for (int n = 0; n < 20; n++) send(rnd14(), rnd14(), n % 3);
      drain();
      for (int n = 0; n < 20; n++) begin
         chk(got_y[base+n] == 0, "R7 y with frozen zero weights", got_y[base+n], 0);
         chk(got_e[base+n] == sd[base+n], "R7 e equals d", got_e[base+n], sd[base+n]);
      end

      // R6: update delayed by DL samples
      do_reset();
      adapt_en = 1'b1;
      base = nsent;
      for (int n = 0; n < DL + 2; n++) send(16384, 16384, 0);
      drain();
      for (int n = 0; n <= DL; n++)
         chk(got_y[base+n] == 0, "R6 zero weights before delayed error", got_y[base+n], 0);
      w0 = (16384 * 16384) >>> (15 + MU);
      yv = (w0 * 16384 + 16384) >>> 15;
      chk(got_y[base+DL+1] == yv, "R6 first adapted output", got_y[base+DL+1], yv);

      // R8: identify a 4-tap system from white noise, random spacing (R9)
      do_reset();
      adapt_en = 1'b1;
      base = nsent;
      for (int n = 0; n < 2000; n++) begin
         int x;
         x = rnd14();
         for (int i = NT-1; i > 0; i--) sx[i] = sx[i-1];
         sx[0] = x;
         dacc = 0;
         for (int i = 0; i < NT; i++) dacc += h[i] * sx[i];
         send(x, int'(sat16((dacc + 16384) >>> 15)), int'(seed[20]));
      end
      drain();
      m_first = 0;
      m_last = 0;
      for (int n = 0; n < 256; n++) begin
         m_first += longint'(got_e[base+n]) * got_e[base+n];
         m_last  += longint'(got_e[base+1744+n]) * got_e[base+1744+n];
      end
      m_first /= 256;
      m_last /= 256;
      chk(m_last < 40000, "R8 final error power", m_last, 40000);
      chk(m_last * 16 < m_first, "R8 error power reduction", m_last * 16, m_first);

      // R7: freeze trained weights, outputs follow the frozen set
      adapt_en = 1'b0;
      for (int n = 0; n < 50; n++) send(rnd14(), rnd14(), n % 2);
      drain();

      // R10: weights driven into saturation
      do_reset();
      adapt_en = 1'b1;
      for (int n = 0; n < 600; n++) send(1024, 32767, 0);
      drain();
      chk(got_y[nsent-1] == 4096, "R10 saturated weights output", got_y[nsent-1], 4096);
      adapt_en = 1'b0;
      for (int n = 0; n < NT; n++) send(32767, 32767, 0);
      drain();
      chk(got_y[nsent-1] == 32767, "R3 output saturation", got_y[nsent-1], 32767);
      send(32767, -32768, 0);
      drain();
      chk(got_e[nsent-1] == -32768, "R4 error saturation", got_e[nsent-1], -32768);

      // R1: reset after training clears weights and delay line
      do_reset();
      send(1000, 5, 0);
      drain();
      chk(got_y[nsent-1] == 0, "R1 weights cleared", got_y[nsent-1], 0);
      chk(got_e[nsent-1] == 5, "R1 error after reset", got_e[nsent-1], 5);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule